// File: doc/BRIEF.md
# Tag-Addressed Shared Cell Buffer

This block is the shared cell store of a small N-port cell switch. A single buffer RAM holds the cells of all output ports together. Beside each RAM slot sits one entry of a content-addressable tag array that says which output port owns the slot and where the cell falls in that port's sequence. A writer hands in a cell and its destination port. The block places the cell in the lowest-numbered free slot and labels it with the port number and that port's next write sequence value. A reader names an output port. The block looks for the tag that pairs the port with the port's current read sequence value, returns the cell from that slot, and frees the slot.

The per-port FIFO order comes from two small per-port counter RAMs, one for writes and one for reads. The slots themselves carry no order. Sequence values wrap modulo 2^SEQW. SEQW must be at least log2 of the buffer depth, so that the live tags of any one port stay distinct. A write is accepted when the buffer is not full. A read request is accepted in every cycle and is answered one cycle later, either with the cell or with a miss flag.

Top module: `cam_cell_buffer`

## Requirements
- R1: While reset is held and after it is released, empty is 1, full is 0, wrReady is 1, and both outValid and outMiss are 0 until the first read request.
- R2: wrReady equals the inverse of full. full is 1 exactly when all DEPTH slots hold a cell. A write is taken at a clock edge where wrValid and wrReady are both 1.
- R3: A write offered while the buffer is full is dropped. No stored cell changes, and the port's write sequence does not advance, so the later reads of every port return exactly the cells that were accepted, in order.
- R4: A read request (rdValid=1, port on rdPort) for a port that holds cells gives outValid=1 and outMiss=0 in the next cycle. outCell then carries that port's oldest accepted cell.
- R5: A read request for a port that holds no cell gives outMiss=1 and outValid=0 in the next cycle. It changes no stored state, and in a cycle without a read request both flags are 0.
- R6: Cells of different ports may be interleaved in any way. Each port still returns its own cells in the order they were accepted.
- R7: Order is kept when more than 2^SEQW cells pass through one port, so the sequence counters wrap.
- R8: A slot freed by a read can be written from the following cycle. A write offered in the same cycle as a read on a full buffer is refused.
- R9: A cell written in a cycle is not visible to a read request made in that same cycle. A read of an otherwise empty port in that cycle reports a miss.
- R10: empty is 1 exactly when no slot holds a cell. full and empty are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A cell is offered for storage |
| wrReady | output | 1 | The buffer can take a cell this cycle |
| wrPort | input | PORTW | Destination output port of the offered cell |
| wrCell | input | CELLW | Cell payload |
| rdValid | input | 1 | Read request for one output port |
| rdPort | input | PORTW | Output port being served |
| outValid | output | 1 | outCell holds the answer to the previous cycle's request |
| outMiss | output | 1 | The previous cycle's request found no cell for its port |
| outCell | output | CELLW | Returned cell payload |
| full | output | 1 | Every slot is occupied |
| empty | output | 1 | No slot is occupied |

## Verification
The bench builds the block with 4 ports, 8 slots, 16-bit cells and 3-bit sequence values. With only 8 slots the buffer fills within a few cycles, so the full boundary and the refusal of writes against a read that frees a slot in the same cycle come up often. With 3-bit sequence values, one port wraps its counters after eight cells, and a long single-port run together with a random mixed phase crosses that wrap many times while four queues share the slots.

// File: rtl/cellbuf_pkg.sv
package cellbuf_pkg;
  // Strobes from the control to the datapath for one clock cycle.
  typedef struct packed {
    logic wrGo;  // store the offered cell this edge
    logic rdGo;  // search for the requested port's next cell this edge
  } bufStrobe_t;
endpackage

// File: rtl/cellbuf_ctrl.sv
module cellbuf_ctrl
  import cellbuf_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int SEQW   = 3,
  localparam int PORTW = $clog2(NPORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrValid,
  input  logic [PORTW-1:0] wrPort,
  input  logic             rdValid,
  input  logic [PORTW-1:0] rdPort,
  input  logic             bufFull,
  input  logic             rdHit,
  output logic             wrReady,
  output bufStrobe_t       strobe,
  output logic [SEQW-1:0]  wrSeq,
  output logic [SEQW-1:0]  rdSeq
);

  // Per-port sequence RAMs: the next tag to write and the next tag to read.
  logic [SEQW-1:0] wSeqRam [NPORTS];
  logic [SEQW-1:0] rSeqRam [NPORTS];

  assign wrReady      = !bufFull;
  assign strobe.wrGo  = wrValid && !bufFull;
  assign strobe.rdGo  = rdValid;
  assign wrSeq        = wSeqRam[wrPort];
  assign rdSeq        = rSeqRam[rdPort];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) begin
        wSeqRam[p] <= '0;
        rSeqRam[p] <= '0;
      end
    end else begin
      // A refused write or a missed read leaves the counters alone.
      if (strobe.wrGo)
        wSeqRam[wrPort] <= wSeqRam[wrPort] + 1'b1;
      if (strobe.rdGo && rdHit)
        rSeqRam[rdPort] <= rSeqRam[rdPort] + 1'b1;
    end
  end

endmodule

// File: rtl/cellbuf_datapath.sv
module cellbuf_datapath
  import cellbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CELLW = 16,
  parameter int PORTW = 2,
  parameter int SEQW  = 3,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bufStrobe_t       strobe,
  input  logic [PORTW-1:0] wrPort,
  input  logic [SEQW-1:0]  wrSeq,
  input  logic [CELLW-1:0] wrCell,
  input  logic [PORTW-1:0] rdPort,
  input  logic [SEQW-1:0]  rdSeq,
  output logic             rdHit,
  output logic             bufFull,
  output logic             bufEmpty,
  output logic             outValid,
  output logic             outMiss,
  output logic [CELLW-1:0] outCell
);

  // Cell RAM and the tag array that labels each slot.
  logic [CELLW-1:0] cellRam  [DEPTH];
  logic [PORTW-1:0] tagPort  [DEPTH];
  logic [SEQW-1:0]  tagSeq   [DEPTH];
  logic [DEPTH-1:0] slotUsed;

  logic [DEPTH-1:0] matchVec;
  logic [DEPTH-1:0] freeVec;
  logic [IDXW-1:0]  matchIdx;
  logic [IDXW-1:0]  freeIdx;

  // One comparator per tag entry.
  for (genvar e = 0; e < DEPTH; e++) begin : g_tagCmp
    assign matchVec[e] = slotUsed[e] && (tagPort[e] == rdPort) && (tagSeq[e] == rdSeq);
    assign freeVec[e]  = !slotUsed[e];
  end

  // Lowest-index priority encoders for the match and free searches.
  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int e = DEPTH - 1; e >= 0; e--) begin
      if (matchVec[e]) matchIdx = IDXW'(e);
      if (freeVec[e])  freeIdx  = IDXW'(e);
    end
  end

  assign rdHit    = |matchVec;
  assign bufFull  = &slotUsed;
  assign bufEmpty = ~|slotUsed;

  // Occupancy: the slot a read frees becomes free only after this edge,
  // so it can never be chosen by a write in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotUsed <= '0;
    end else begin
      if (strobe.wrGo)
        slotUsed[freeIdx] <= 1'b1;
      if (strobe.rdGo && rdHit)
        slotUsed[matchIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrGo) begin
      cellRam[freeIdx] <= wrCell;
      tagPort[freeIdx] <= wrPort;
      tagSeq[freeIdx]  <= wrSeq;
    end
  end

  // Registered read answer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outMiss  <= 1'b0;
      outCell  <= '0;
    end else begin
      outValid <= strobe.rdGo && rdHit;
      outMiss  <= strobe.rdGo && !rdHit;
      if (strobe.rdGo && rdHit)
        outCell <= cellRam[matchIdx];
    end
  end

endmodule

// File: rtl/cam_cell_buffer.sv
module cam_cell_buffer
  import cellbuf_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 8,
  parameter int CELLW  = 16,
  parameter int SEQW   = 3,
  localparam int PORTW = $clog2(NPORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrValid,
  output logic             wrReady,
  input  logic [PORTW-1:0] wrPort,
  input  logic [CELLW-1:0] wrCell,
  input  logic             rdValid,
  input  logic [PORTW-1:0] rdPort,
  output logic             outValid,
  output logic             outMiss,
  output logic [CELLW-1:0] outCell,
  output logic             full,
  output logic             empty
);

  bufStrobe_t      strobe;
  logic [SEQW-1:0] wrSeq;
  logic [SEQW-1:0] rdSeq;
  logic            rdHit;

  cellbuf_ctrl #(.NPORTS(NPORTS), .SEQW(SEQW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wrValid(wrValid), .wrPort(wrPort),
    .rdValid(rdValid), .rdPort(rdPort),
    .bufFull(full), .rdHit(rdHit),
    .wrReady(wrReady), .strobe(strobe),
    .wrSeq(wrSeq), .rdSeq(rdSeq)
  );

  cellbuf_datapath #(.DEPTH(DEPTH), .CELLW(CELLW), .PORTW(PORTW), .SEQW(SEQW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrPort(wrPort), .wrSeq(wrSeq), .wrCell(wrCell),
    .rdPort(rdPort), .rdSeq(rdSeq), .rdHit(rdHit),
    .bufFull(full), .bufEmpty(empty),
    .outValid(outValid), .outMiss(outMiss), .outCell(outCell)
  );

endmodule

// File: rtl/cellbuf_checker.sv
module cellbuf_checker (
  input logic clk,
  input logic rst_n,
  input logic wrValid,
  input logic wrReady,
  input logic rdValid,
  input logic outValid,
  input logic outMiss,
  input logic full,
  input logic empty
);

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wrReady);  // R2

  AST_FULL_EMPTY_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));  // R10

  AST_ANSWER_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(outValid && outMiss));  // R4

  AST_NO_REQUEST_NO_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |=> (!outValid && !outMiss));  // R5

  AST_EMPTY_READ_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && empty) |=> outMiss);  // R5

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(wrValid && wrReady)) |=> empty);  // R10

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rdValid) |=> full);  // R8

endmodule

bind cam_cell_buffer cellbuf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
  .rdValid(rdValid), .outValid(outValid), .outMiss(outMiss),
  .full(full), .empty(empty)
);

// File: tb/cam_cell_buffer_tb.sv
`timescale 1ns/1ps
module cam_cell_buffer_tb;
  localparam int NPORTS = 4;
  localparam int DEPTH  = 8;
  localparam int CELLW  = 16;
  localparam int SEQW   = 3;
  localparam int PORTW  = $clog2(NPORTS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0, rdValid = 1'b0;
  logic [PORTW-1:0] wrPort = '0, rdPort = '0;
  logic [CELLW-1:0] wrCell = '0;
  logic wrReady, outValid, outMiss, full, empty;
  logic [CELLW-1:0] outCell;

  int nChecks = 0;
  int nFails  = 0;
  string phaseReq = "R4";
  logic [CELLW-1:0] nextCell = 16'h0100;

  always #4 clk = ~clk;  // 125 MHz

  cam_cell_buffer #(.NPORTS(NPORTS), .DEPTH(DEPTH), .CELLW(CELLW), .SEQW(SEQW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrReady(wrReady),
    .wrPort(wrPort), .wrCell(wrCell), .rdValid(rdValid), .rdPort(rdPort),
    .outValid(outValid), .outMiss(outMiss), .outCell(outCell),
    .full(full), .empty(empty)
  );

  // Behavioural reference: one queue per port.
  logic [CELLW-1:0] refQ [NPORTS][$];
  logic expValid = 1'b0, expMiss = 1'b0;
  logic [CELLW-1:0] expCell = '0;
  int refTotal = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) refQ[p].delete();
      expValid = 1'b0; expMiss = 1'b0; refTotal = 0;
    end else begin
      automatic bit takeWr = wrValid && (refTotal < DEPTH);
      expValid = 1'b0; expMiss = 1'b0;
      if (rdValid) begin
        if (refQ[rdPort].size() > 0) begin
          expValid = 1'b1;
          expCell  = refQ[rdPort].pop_front();
        end else begin
          expMiss = 1'b1;
        end
      end
      if (takeWr) refQ[wrPort].push_back(wrCell);
      refTotal = 0;
      for (int p = 0; p < NPORTS; p++) refTotal += refQ[p].size();
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "full", int'(full), int'(refTotal == DEPTH));
      chk("R2", "wrReady", int'(wrReady), int'(refTotal != DEPTH));
      chk("R10", "empty", int'(empty), int'(refTotal == 0));
      chk(phaseReq, "outValid", int'(outValid), int'(expValid));
      chk(phaseReq, "outMiss", int'(outMiss), int'(expMiss));
      if (expValid) chk(phaseReq, "outCell", int'(outCell), int'(expCell));
    end
  end

  task automatic cyc(input bit wv, input int wp, input bit rv, input int rp);
    @(posedge clk); #1;
    wrValid = wv; wrPort = PORTW'(wp); rdValid = rv; rdPort = PORTW'(rp);
    if (wv) begin
      wrCell = nextCell;
      nextCell = nextCell + 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values while held
    chk("R1", "empty in reset", int'(empty), 1);
    chk("R1", "full in reset", int'(full), 0);
    chk("R1", "wrReady in reset", int'(wrReady), 1);
    chk("R1", "outValid in reset", int'(outValid), 0);
    chk("R1", "outMiss in reset", int'(outMiss), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: fill to the last slot across ports
    phaseReq = "R2";
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, i % NPORTS, 1'b0, 0);
    // R3: writes offered while full are dropped
    phaseReq = "R3";
    cyc(1'b1, 0, 1'b0, 0);
    cyc(1'b1, 3, 1'b0, 0);
    // R8: read on a full buffer with a write in the same cycle; then refill
    phaseReq = "R8";
    cyc(1'b1, 1, 1'b1, 0);
    cyc(1'b1, 1, 1'b0, 0);
    cyc(1'b1, 2, 1'b0, 0);
    // R4 / R6: drain all ports in round robin, including extra misses (R5)
    phaseReq = "R6";
    for (int i = 0; i < 2 * DEPTH + 4; i++) cyc(1'b0, 0, 1'b1, i % NPORTS);
    phaseReq = "R5";
    cyc(1'b0, 0, 1'b1, 3);
    idle(1);
    // R9: write and read of the same empty port in one cycle
    phaseReq = "R9";
    cyc(1'b1, 2, 1'b1, 2);
    cyc(1'b0, 0, 1'b1, 2);
    cyc(1'b0, 0, 1'b1, 2);
    // R7: long run through one port, wrapping the sequence counters
    phaseReq = "R7";
    for (int i = 0; i < 5; i++) cyc(1'b1, 1, 1'b0, 0);
    for (int i = 0; i < 4 * (1 << SEQW); i++) cyc(1'b1, 1, 1'b1, 1);
    for (int i = 0; i < 6; i++) cyc(1'b0, 0, 1'b1, 1);
    // R4: random mix of writes and reads on all ports
    phaseReq = "R4";
    for (int i = 0; i < 600; i++)
      cyc(($urandom % 4) != 0, $urandom % NPORTS, ($urandom % 3) != 0, $urandom % NPORTS);
    for (int i = 0; i < 3 * DEPTH; i++) cyc(1'b0, 0, 1'b1, i % NPORTS);
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule